// File: doc/BRIEF.md
# SCSI DMA Handshake Engine

This block carries bytes between a host DMA port (request, acknowledge, end-of-process and a block-mode pacing line) and the SCSI REQ/ACK byte handshake. It can act as the bus target, driving REQ, or as the initiator, driving ACK. It can send bytes to the bus or receive them from it. The host side runs in one of two modes. In normal mode each byte is requested with its own request pulse. In block mode the request line stays high for the whole transfer and a separate ready line paces the bytes.

A one-byte holding register sits between the two sides. The transfer runs only while the observed bus phase equals the programmed phase. A phase mismatch or an end-of-process pulse stops the transfer and raises the interrupt. Once a transfer has ended, the DMA enable input must be dropped and raised again before a new start is accepted. Dropping the enable clears all DMA state.

Top module: `scsi_dma_hs`

## Requirements
- R1: After reset, and in the cycle after `dma_en_i` is seen low, `drq_o`, `ready_o`, `req_o`, `ack_o` and `end_dma_o` are 0. `irq_o` is 0 after reset.
- R2: A one-cycle pulse on `start_send_i` (send) or `start_recv_i` (receive) starts a transfer only when `dma_en_i` is 1 and no transfer has ended since `dma_en_i` last rose. A start while `dma_en_i` is 0, or after a finished transfer without toggling `dma_en_i`, leaves `drq_o` at 0.
- R3: The 3-bit phase vector is {C/D, MSG, I/O}. If `scsi_phase_i` differs from `exp_phase_i` in any bit while a transfer runs, the transfer stops at the next edge: `req_o`, `ack_o` and `drq_o` go to 0, `irq_o` goes to 1, and `end_dma_o` stays 0.
- R4: `eop_i` high for one cycle during a transfer stops it at the next edge. `end_dma_o` and `irq_o` go to 1 and `drq_o` goes to 0.
- R5: In normal mode (`blk_mode_i`=0) `drq_o` requests one byte at a time and `ready_o` stays 0. In block mode `drq_o` stays at 1 for the whole transfer and `ready_o` marks the cycles in which `dack_i` moves a byte.
- R6: As target (`role_tgt_i`=1), `req_o` rises when a byte is held (send) or when the holding register is empty (receive). `req_o` falls in the cycle after `ack_i` is seen high. It does not rise again until `ack_i` has gone low.
- R7: As initiator, `ack_o` rises after `req_i` is seen with the holding register ready. On send, `ack_o` falls after `req_i` goes low. On receive, `ack_o` also waits until the host has taken the byte and `dack_i` is low again, which is two cycles after the `dack_i` pulse begins.
- R8: In every role, direction and mode, bytes reach the other side unchanged and in order.
- R9: `irq_o` holds until a `irq_clr_i` pulse. `end_dma_o` holds until `dma_en_i` goes low.
- R10: Dropping `dma_en_i` during a transfer stops it without raising `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA enable; low clears all DMA state |
| role_tgt_i | input | 1 | 1 = target role, 0 = initiator; latched at start |
| blk_mode_i | input | 1 | 1 = block mode; latched at start |
| exp_phase_i | input | PW | Expected {C/D, MSG, I/O} |
| start_send_i | input | 1 | Start-send strobe |
| start_recv_i | input | 1 | Start-receive strobe |
| eop_i | input | 1 | End-of-process from host |
| irq_clr_i | input | 1 | Interrupt acknowledge strobe |
| drq_o | output | 1 | DMA request to host |
| ready_o | output | 1 | Block-mode byte pacing |
| dack_i | input | 1 | Host DMA acknowledge / byte strobe |
| host_wdata_i | input | DW | Byte from host (send) |
| host_rdata_o | output | DW | Byte to host (receive) |
| scsi_phase_i | input | PW | Observed {C/D, MSG, I/O} |
| req_i | input | 1 | REQ from bus (initiator role) |
| ack_i | input | 1 | ACK from bus (target role) |
| req_o | output | 1 | REQ drive (target role) |
| ack_o | output | 1 | ACK drive (initiator role) |
| scsi_data_i | input | DW | Bus data in |
| scsi_data_o | output | DW | Bus data out |
| scsi_data_oe_o | output | 1 | Bus data output enable (send) |
| irq_o | output | 1 | Interrupt |
| end_dma_o | output | 1 | Transfer ended by end-of-process |

## Verification
A corrupted holding-register flag shows up within one byte. Either the request line fails to come back, so the bench stalls and the watchdog fires, or a byte is repeated or dropped, and the bench catches that on the next data compare. A wrong handshake state shows as REQ or ACK staying high one cycle too long or too short, and the per-edge checks around each ACK or DACK pulse catch it. A lost stop or re-arm flag shows one cycle after the mismatch, EOP or restart stimulus, through `irq_o`, `end_dma_o` or `drq_o`.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_ASSERT  = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic tgt;
    logic blk;
    logic send;
  } xfer_cfg_t;
endpackage

// File: rtl/sdh_ctrl.sv
module sdh_ctrl
  import scsi_dma_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dma_en_i,
  input  logic      start_send_i,
  input  logic      start_recv_i,
  input  logic      role_tgt_i,
  input  logic      blk_mode_i,
  input  logic      phase_ok_i,
  input  logic      eop_i,
  input  logic      irq_clr_i,
  output logic      active_o,
  output xfer_cfg_t cfg_o,
  output logic      stop_o,
  output logic      irq_o,
  output logic      end_dma_o
);
  logic      active_q, spent_q, irq_q, end_q;
  xfer_cfg_t cfg_q;

  assign stop_o = active_q && dma_en_i && (eop_i || !phase_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      spent_q  <= 1'b0;
      end_q    <= 1'b0;
      cfg_q    <= '0;
    end else if (!dma_en_i) begin
      active_q <= 1'b0;
      spent_q  <= 1'b0;
      end_q    <= 1'b0;
    end else if (active_q) begin
      if (stop_o) begin
        active_q <= 1'b0;
        spent_q  <= 1'b1;
        if (eop_i) end_q <= 1'b1;
      end
    end else if ((start_send_i || start_recv_i) && !spent_q) begin
      active_q <= 1'b1;
      cfg_q    <= '{tgt: role_tgt_i, blk: blk_mode_i, send: start_send_i};
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (stop_o)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign active_o  = active_q;
  assign cfg_o     = cfg_q;
  assign irq_o     = irq_q;
  assign end_dma_o = end_q;
endmodule

// File: rtl/sdh_buf.sv
module sdh_buf #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  logic [DW-1:0] data_q;
  logic          full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= wdata_i;
      full_q <= 1'b1;
    end else if (rd_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/sdh_hs.sv
module sdh_hs
  import scsi_dma_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tgt_i,
  input  logic          send_i,
  input  logic          full_i,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic          dack_i,
  input  logic [DW-1:0] buf_i,
  output logic          hs_o,
  output logic          consume_o,
  output logic          capture_o,
  output logic [DW-1:0] dout_o
);
  hs_state_e     st_q, st_d;
  logic [DW-1:0] dout_q;
  logic          buf_ready;

  // send needs a held byte, receive needs an empty slot
  assign buf_ready = send_i ? full_i : !full_i;

  always_comb begin
    st_d      = st_q;
    consume_o = 1'b0;
    capture_o = 1'b0;
    if (!run_i) begin
      st_d = HS_IDLE;
    end else begin
      case (st_q)
        HS_IDLE: begin
          if ((tgt_i || req_i) && buf_ready) begin
            st_d      = HS_ASSERT;
            consume_o = send_i;
            capture_o = !send_i && !tgt_i;
          end
        end
        HS_ASSERT: begin
          if (tgt_i) begin
            if (ack_i) begin
              st_d      = HS_RELEASE;
              capture_o = !send_i;
            end
          end else if (!req_i && (send_i || (!full_i && !dack_i))) begin
            st_d = HS_IDLE;
          end
        end
        HS_RELEASE: begin
          if (!ack_i) st_d = HS_IDLE;
        end
        default: st_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HS_IDLE;
      dout_q <= '0;
    end else begin
      st_q <= st_d;
      if (consume_o) dout_q <= buf_i;
    end
  end

  assign hs_o   = (st_q == HS_ASSERT);
  assign dout_o = dout_q;
endmodule

// File: rtl/scsi_dma_hs.sv
module scsi_dma_hs
  import scsi_dma_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_en_i,
  input  logic          role_tgt_i,
  input  logic          blk_mode_i,
  input  logic [PW-1:0] exp_phase_i,
  input  logic          start_send_i,
  input  logic          start_recv_i,
  input  logic          eop_i,
  input  logic          irq_clr_i,
  output logic          drq_o,
  output logic          ready_o,
  input  logic          dack_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [PW-1:0] scsi_phase_i,
  input  logic          req_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          ack_o,
  input  logic [DW-1:0] scsi_data_i,
  output logic [DW-1:0] scsi_data_o,
  output logic          scsi_data_oe_o,
  output logic          irq_o,
  output logic          end_dma_o
);
  logic          active, stop, phase_ok;
  xfer_cfg_t     cfg;
  logic          full, host_rdy, host_take;
  logic          hs, consume, capture;
  logic          buf_wr, buf_rd, buf_clr;
  logic [DW-1:0] buf_wdata, buf_data;

  assign phase_ok = (scsi_phase_i == exp_phase_i);

  sdh_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dma_en_i    (dma_en_i),
    .start_send_i(start_send_i),
    .start_recv_i(start_recv_i),
    .role_tgt_i  (role_tgt_i),
    .blk_mode_i  (blk_mode_i),
    .phase_ok_i  (phase_ok),
    .eop_i       (eop_i),
    .irq_clr_i   (irq_clr_i),
    .active_o    (active),
    .cfg_o       (cfg),
    .stop_o      (stop),
    .irq_o       (irq_o),
    .end_dma_o   (end_dma_o)
  );

  // host side: empty slot on send, held byte on receive
  assign host_rdy  = active && (cfg.send ? !full : full);
  assign host_take = dack_i && host_rdy;

  assign buf_wr    = cfg.send ? host_take : capture;
  assign buf_wdata = cfg.send ? host_wdata_i : scsi_data_i;
  assign buf_rd    = cfg.send ? consume : host_take;
  assign buf_clr   = !active || stop;

  sdh_buf #(.DW(DW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (buf_clr),
    .wr_i   (buf_wr),
    .wdata_i(buf_wdata),
    .rd_i   (buf_rd),
    .data_o (buf_data),
    .full_o (full)
  );

  sdh_hs #(.DW(DW)) u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active && !stop),
    .tgt_i    (cfg.tgt),
    .send_i   (cfg.send),
    .full_i   (full),
    .req_i    (req_i),
    .ack_i    (ack_i),
    .dack_i   (dack_i),
    .buf_i    (buf_data),
    .hs_o     (hs),
    .consume_o(consume),
    .capture_o(capture),
    .dout_o   (scsi_data_o)
  );

  assign drq_o          = active && (cfg.blk || host_rdy);
  assign ready_o        = active && cfg.blk && host_rdy;
  assign req_o          = active && cfg.tgt && hs;
  assign ack_o          = active && !cfg.tgt && hs;
  assign scsi_data_oe_o = active && cfg.send;
  assign host_rdata_o   = buf_data;
endmodule

// File: rtl/scsi_dma_hs_chk.sv
module scsi_dma_hs_chk #(
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dma_en_i,
  input logic [PW-1:0] exp_phase_i,
  input logic [PW-1:0] scsi_phase_i,
  input logic          eop_i,
  input logic          irq_clr_i,
  input logic          drq_o,
  input logic          ready_o,
  input logic          req_i,
  input logic          ack_i,
  input logic          req_o,
  input logic          ack_o,
  input logic          irq_o,
  input logic          end_dma_o
);
  logic ph_eq;
  assign ph_eq = (scsi_phase_i == exp_phase_i);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |=> (!drq_o && !ready_o && !req_o && !ack_o && !end_dma_o)); // R1
  AST_MISMATCH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ph_eq && dma_en_i) |=> (irq_o && !req_o)); // R3
  AST_EOP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && eop_i && dma_en_i) |=> (end_dma_o && irq_o && !drq_o)); // R4
  AST_READY_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> drq_o); // R5
  AST_HS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !ack_o); // R6
  AST_TGT_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o); // R6
  AST_INI_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i && ph_eq && !eop_i && dma_en_i) |=> ack_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o); // R9
endmodule

bind scsi_dma_hs scsi_dma_hs_chk #(.PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dma_en_i    (dma_en_i),
  .exp_phase_i (exp_phase_i),
  .scsi_phase_i(scsi_phase_i),
  .eop_i       (eop_i),
  .irq_clr_i   (irq_clr_i),
  .drq_o       (drq_o),
  .ready_o     (ready_o),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .ack_o       (ack_o),
  .irq_o       (irq_o),
  .end_dma_o   (end_dma_o)
);

// File: tb/scsi_dma_hs_tb_top.sv
`timescale 1ns/1ps
module scsi_dma_hs_tb_top;
  localparam int DW = 8;
  localparam int PW = 3;
  localparam int NB = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_en_i = 1'b0, role_tgt_i = 1'b0, blk_mode_i = 1'b0;
  logic [PW-1:0] exp_phase_i = '0, scsi_phase_i = '0;
  logic start_send_i = 1'b0, start_recv_i = 1'b0, eop_i = 1'b0, irq_clr_i = 1'b0;
  logic dack_i = 1'b0, req_i = 1'b0, ack_i = 1'b0;
  logic [DW-1:0] host_wdata_i = '0, scsi_data_i = '0;
  logic drq_o, ready_o, req_o, ack_o, scsi_data_oe_o, irq_o, end_dma_o;
  logic [DW-1:0] host_rdata_o, scsi_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  scsi_dma_hs #(.DW(DW), .PW(PW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int c, input int i);
    return DW'((c * 37 + i * 11 + 3) & 255);
  endfunction

  task automatic tick(); @(negedge clk_i); endtask

  task automatic do_start(input logic snd);
    start_send_i = snd;
    start_recv_i = !snd;
    tick();
    start_send_i = 1'b0;
    start_recv_i = 1'b0;
  endtask

  task automatic rearm();
    irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0;
    dma_en_i = 1'b0;  tick(); dma_en_i = 1'b1; tick();
  endtask

  task automatic host_run(input int n, input logic snd, input logic blk, input int c);
    for (int i = 0; i < n; i++) begin
      while (!(blk ? ready_o : drq_o)) begin
        if (!blk) chk(!ready_o, "R5 ready in normal mode", ready_o, 0);
        tick();
      end
      if (blk) chk(drq_o, "R5 drq held in block mode", drq_o, 1);
      else     chk(!ready_o, "R5 ready in normal mode", ready_o, 0);
      if (snd) host_wdata_i = pat(c, i);
      else chk(host_rdata_o == pat(c, i), "R8 host byte", host_rdata_o, pat(c, i));
      dack_i = 1'b1; tick(); dack_i = 1'b0; tick();
    end
  endtask

  task automatic peer_run(input int n, input logic snd, input logic tgt, input int c);
    for (int i = 0; i < n; i++) begin
      if (tgt) begin
        while (!req_o) tick();
        if (snd) chk(scsi_data_o == pat(c, i), "R8 bus byte", scsi_data_o, pat(c, i));
        else scsi_data_i = pat(c, i);
        ack_i = 1'b1; tick();
        chk(!req_o, "R6 req drop after ack", req_o, 0);
        tick();
        chk(!req_o, "R6 req low while ack", req_o, 0);
        ack_i = 1'b0; tick();
      end else begin
        if (!snd) scsi_data_i = pat(c, i);
        req_i = 1'b1;
        while (!ack_o) tick();
        if (snd) chk(scsi_data_o == pat(c, i), "R8 bus byte", scsi_data_o, pat(c, i));
        req_i = 1'b0;
        while (ack_o) tick();
      end
    end
  endtask

  initial begin
    #(150000 * 4);
    n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk(!drq_o && !ready_o && !req_o && !ack_o, "R1 handshake idle after reset", drq_o, 0);
    chk(!irq_o && !end_dma_o, "R1 flags clear after reset", irq_o, 0);

    // R2: start while disabled
    do_start(1'b1);
    chk(!drq_o, "R2 start ignored while disabled", drq_o, 0);

    // full sweep: role x direction x mode
    for (int c = 0; c < 8; c++) begin
      logic tgt_b, snd_b, blk_b;
      tgt_b = c[0]; snd_b = c[1]; blk_b = c[2];
      role_tgt_i = tgt_b; blk_mode_i = blk_b;
      exp_phase_i = PW'(c); scsi_phase_i = PW'(c);
      dma_en_i = 1'b1; tick();
      do_start(snd_b);
      chk(scsi_data_oe_o == snd_b, "R8 data drive enable", scsi_data_oe_o, snd_b);
      fork
        host_run(NB, snd_b, blk_b, c);
        peer_run(NB, snd_b, tgt_b, c);
      join
      chk(!irq_o, "R9 no irq mid transfer", irq_o, 0);
      eop_i = 1'b1; tick(); eop_i = 1'b0;
      chk(end_dma_o && irq_o, "R4 eop sets end and irq", {end_dma_o, irq_o}, 3);
      chk(!drq_o && !req_o && !ack_o, "R4 eop halts", drq_o, 0);
      irq_clr_i = 1'b1; tick(); irq_clr_i = 1'b0;
      chk(!irq_o, "R9 irq cleared by strobe", irq_o, 0);
      chk(end_dma_o, "R9 end flag holds", end_dma_o, 1);
      do_start(snd_b);
      chk(!drq_o && !req_o, "R2 restart needs enable toggle", drq_o, 0);
      dma_en_i = 1'b0; tick();
      chk(!end_dma_o && !drq_o && !req_o && !ack_o, "R1 quiet when disabled", end_dma_o, 0);
    end

    // R3: phase mismatch, target send normal mode
    role_tgt_i = 1'b1; blk_mode_i = 1'b0; exp_phase_i = 3'b101; scsi_phase_i = 3'b101;
    dma_en_i = 1'b1; tick();
    do_start(1'b1);
    host_wdata_i = 8'h5a; dack_i = 1'b1; tick(); dack_i = 1'b0;
    while (!req_o) tick();
    scsi_phase_i = 3'b111; tick();
    chk(!req_o && !drq_o, "R3 mismatch halts", req_o, 0);
    chk(irq_o, "R3 mismatch raises irq", irq_o, 1);
    chk(!end_dma_o, "R3 mismatch not end of dma", end_dma_o, 0);
    scsi_phase_i = 3'b101;
    rearm();

    // R10: disable mid transfer
    do_start(1'b1);
    chk(drq_o, "R10 transfer running", drq_o, 1);
    dma_en_i = 1'b0; tick();
    chk(!drq_o && !irq_o, "R10 disable aborts silently", {drq_o, irq_o}, 0);
    dma_en_i = 1'b1; tick();

    // R7: initiator receive holds ack until host read
    role_tgt_i = 1'b0; blk_mode_i = 1'b0;
    do_start(1'b0);
    scsi_data_i = 8'hc3; req_i = 1'b1;
    while (!ack_o) tick();
    req_i = 1'b0;
    repeat (3) tick();
    chk(ack_o, "R7 ack held until host read", ack_o, 1);
    chk(host_rdata_o == 8'hc3, "R8 captured byte", host_rdata_o, 8'hc3);
    dack_i = 1'b1; tick(); dack_i = 1'b0;
    chk(ack_o, "R7 ack held during dack", ack_o, 1);
    tick();
    chk(!ack_o, "R7 ack released after dack", ack_o, 0);
    eop_i = 1'b1; tick(); eop_i = 1'b0;
    rearm();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule